// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block is a two-wire serial slave that lets an external bus controller read and write a small bank of 8-bit control registers. SCL and SDA arrive as plain inputs and are oversampled on the system clock through a short synchronizer. The slave answers by pulling SDA low through an open-drain enable. The register bank is presented to the rest of the chip as one flat vector, with a one-cycle write strobe per byte. Every register comes out of reset at its default value, so the chip works even if the bus is never used. The block has no dependency on the power state of its neighbours.

The command byte that follows the write address selects the kind of access. With its top bit set, the lower seven bits name one register for a single-byte write or read. With its top bit clear, the access is a block transfer that always starts at register 0 and walks upward. A block write carries a byte-count byte ahead of its data. A block read returns a byte count ahead of the register contents. Every read first sends the command in a write phase, then issues a repeated start with the read address. A stop after any complete byte ends a block transfer and keeps everything written so far.

Top module: `smb_regslave`

## Requirements
- R1: The slave acknowledges only the address byte D2h (write) and D3h (read), that is 7-bit address 69h with the direction in bit 0. For any other address byte it leaves SDA released for the acknowledge and for every following bit until the next start.
- R2: A command byte with bit 7 = 1 followed by one data byte stores that data in the register whose offset is given by command bits 6:0. The command and the data are both acknowledged.
- R3: A command byte with bit 7 = 1, then a repeated start and address D3h, returns the register at offset bits 6:0, most significant bit first.
- R4: A command byte of 00h, a byte-count byte and N data bytes store the data in registers 0, 1, 2 and upward. The slave acknowledges the count byte and each data byte. The count value does not limit how many bytes are stored.
- R5: After command 00h, a repeated start and D3h, the slave first returns a count byte equal to the number of implemented registers (0Fh by default). It then returns register 0, 1 and upward, until the master sends a NACK and a stop.
- R6: A stop after any complete data byte ends a block write. Every byte already acknowledged keeps its new value, and no later register changes.
- R7: A write to an offset at or beyond the number of implemented registers is acknowledged and changes no register. A read from such an offset, including past the end of a block read, returns 00h.
- R8: After reset every register holds its default value (5Ah for each byte by default), no write strobe is active and SDA is released.
- R9: Each stored byte raises exactly one write strobe, for one cycle, on that register's strobe bit. A register without a strobe holds its value.
- R10: A stop or a start that arrives part-way through a data byte discards the partial byte and changes no register. A start begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, the open-drain pad pulls SDA low |
| reg_q | output | NUM_REGS*8 | Register bank, register i at bits 8*i+7 down to 8*i |
| reg_wstb | output | NUM_REGS | One-cycle pulse on bit i when register i is written |

## Verification
Each SCL edge takes two synchronizer flops before the control logic sees it. The SDA enable therefore changes three clock edges after SCL falls. A stored byte appears on reg_q, together with its strobe, three edges after the falling SCL edge that ends its eighth bit. The bench keeps SCL low for eight clocks before each rising edge, and it samples the bus at the middle of the SCL-high phase, so every acknowledge and read bit has settled when it is taken. Register contents and strobe totals are compared with a bench model only after each stop, well after the last write is due.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_CMD   = 3'd2,
    ST_COUNT = 3'd3,
    ST_WDATA = 3'd4,
    ST_RDATA = 3'd5
  } smb_state_e;

endpackage

// File: rtl/smb_front.sv
module smb_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_n,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [1:0]       rst_pipe;
  logic [CHAIN-1:0] scl_pipe;
  logic [CHAIN-1:0] sda_pipe;
  logic             scl_d;
  logic             sda_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) rst_pipe <= 2'b00;
    else           rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  // bus idles high, so the chain resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[CHAIN-2:0], scl_i};
      sda_pipe <= {sda_pipe[CHAIN-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[CHAIN-2];
  assign scl_d = scl_pipe[CHAIN-1];
  assign sda_s = sda_pipe[CHAIN-2];
  assign sda_d = sda_pipe[CHAIN-1];

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_evt =  scl_s &  scl_d & ~sda_s &  sda_d;
  assign stop_evt  =  scl_s &  scl_d &  sda_s & ~sda_d;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int                    NUM_REGS = 15,
  parameter int                    AW       = 7,
  parameter logic [NUM_REGS*8-1:0] RST_VAL  = {NUM_REGS{8'h5A}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] reg_q,
  output logic [NUM_REGS-1:0]   reg_wstb
);

  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit[i] = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[i*8 +: 8] <= RST_VAL[i*8 +: 8];
        reg_wstb[i]     <= 1'b0;
      end else begin
        reg_wstb[i] <= hit[i];
        if (hit[i]) reg_q[i*8 +: 8] <= wr_data;
      end
    end

    // R9: a register moves only with its strobe
    a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wstb[i] |-> $stable(reg_q[i*8 +: 8]));
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == AW'(i)) rd_data = reg_q[i*8 +: 8];
    end
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wstb));

  a_r7_no_strobe_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> (reg_wstb == '0));

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter int                    NUM_REGS    = 15,
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RST_VAL     = {NUM_REGS{8'h5A}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_q,
  output logic [NUM_REGS-1:0]   reg_wstb
);

  localparam int         AW      = 7;
  localparam logic [7:0] CNT_VAL = 8'(NUM_REGS);
  localparam logic [AW-1:0] PTR_MAX = '1;

  logic rst_sn, scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  smb_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .rst_n     (rst_sn),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smb_state_e   st_q, st_n;
  logic [3:0]   cnt_q, cnt_n;
  logic         in_ack_q, in_ack_n;
  logic         ack_drv_q, ack_drv_n;
  logic         mnack_q, mnack_n;
  logic         need_cnt_q, need_cnt_n;
  logic [7:0]   sh_q, sh_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic         wr_en;
  logic [7:0]   rd_data;
  logic [AW-1:0] ptr_inc;

  assign ptr_inc = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;

  smb_regbank #(.NUM_REGS(NUM_REGS), .AW(AW), .RST_VAL(RST_VAL)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .wr_addr  (ptr_q),
    .wr_data  (sh_q),
    .rd_addr  (ptr_q),
    .rd_data  (rd_data),
    .reg_q    (reg_q),
    .reg_wstb (reg_wstb)
  );

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    in_ack_n   = in_ack_q;
    ack_drv_n  = ack_drv_q;
    mnack_n    = mnack_q;
    need_cnt_n = need_cnt_q;
    sh_n       = sh_q;
    ptr_n      = ptr_q;
    wr_en      = 1'b0;

    if (start_evt) begin
      st_n      = ST_ADDR;
      cnt_n     = 4'd0;
      in_ack_n  = 1'b0;
      ack_drv_n = 1'b0;
    end else if (stop_evt) begin
      st_n      = ST_IDLE;
      cnt_n     = 4'd0;
      in_ack_n  = 1'b0;
      ack_drv_n = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (!in_ack_q) begin
          cnt_n = cnt_q + 4'd1;
          if (st_q != ST_RDATA) sh_n = {sh_q[6:0], sda_s};
        end else if (st_q == ST_RDATA) begin
          mnack_n = sda_s;
        end
      end else if (scl_fall) begin
        if (in_ack_q) begin
          // end of the acknowledge slot
          in_ack_n  = 1'b0;
          ack_drv_n = 1'b0;
          cnt_n     = 4'd0;
          if (st_q == ST_RDATA) begin
            if (mnack_q) begin
              st_n = ST_IDLE;
            end else if (need_cnt_q) begin
              sh_n       = CNT_VAL;
              need_cnt_n = 1'b0;
            end else begin
              sh_n  = rd_data;
              ptr_n = ptr_inc;
            end
          end
        end else if (cnt_q == 4'd8) begin
          // eighth bit done: enter the acknowledge slot
          in_ack_n = 1'b1;
          unique case (st_q)
            ST_ADDR: begin
              if (sh_q[7:1] == DEV_ADDR) begin
                ack_drv_n = 1'b1;
                st_n      = sh_q[0] ? ST_RDATA : ST_CMD;
              end else begin
                in_ack_n = 1'b0;
                st_n     = ST_IDLE;
              end
            end
            ST_CMD: begin
              ack_drv_n  = 1'b1;
              need_cnt_n = ~sh_q[7];
              ptr_n      = sh_q[7] ? sh_q[6:0] : '0;
              st_n       = sh_q[7] ? ST_WDATA : ST_COUNT;
            end
            ST_COUNT: begin
              ack_drv_n = 1'b1;
              st_n      = ST_WDATA;
            end
            ST_WDATA: begin
              ack_drv_n = 1'b1;
              wr_en     = 1'b1;
              ptr_n     = ptr_inc;
            end
            default: begin
              ack_drv_n = 1'b0;
            end
          endcase
        end else if (st_q == ST_RDATA) begin
          sh_n = {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q       <= ST_IDLE;
      cnt_q      <= 4'd0;
      in_ack_q   <= 1'b0;
      ack_drv_q  <= 1'b0;
      mnack_q    <= 1'b0;
      need_cnt_q <= 1'b0;
      sh_q       <= 8'h00;
      ptr_q      <= '0;
    end else begin
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      in_ack_q   <= in_ack_n;
      ack_drv_q  <= ack_drv_n;
      mnack_q    <= mnack_n;
      need_cnt_q <= need_cnt_n;
      sh_q       <= sh_n;
      ptr_q      <= ptr_n;
    end
  end

  assign sda_oe = ack_drv_q | ((st_q == ST_RDATA) & ~in_ack_q & ~sh_q[7]);

  a_r1_released_when_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_IDLE) |-> !sda_oe);

  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_sn)
    start_evt |=> (st_q == ST_ADDR && cnt_q == 4'd0 && !in_ack_q));

  // R3: the slave only moves SDA while SCL is low
  a_r3_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_sn)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

endmodule

// File: tb/tb_smb_regslave.sv
module tb_smb_regslave;

  localparam int NREG = 15;
  localparam int Q    = 4;

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_bus;
  logic sda_oe;
  logic [NREG*8-1:0] reg_q;
  logic [NREG-1:0]   reg_wstb;

  int vec;
  int bad;
  bit done;
  logic [7:0] model [NREG];
  int exp_stb [NREG];
  int got_stb [NREG];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  smb_regslave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .reg_q    (reg_q),
    .reg_wstb (reg_wstb)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NREG; i++) if (reg_wstb[i]) got_stb[i]++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int off);
    return (off < NREG) ? model[off] : 8'h00;
  endfunction

  task automatic model_wr(input int off, input logic [7:0] d);
    if (off < NREG) begin
      model[off] = d;
      exp_stb[off]++;
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = ~a;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic chk_bank(input string tag);
    repeat (4) @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      chk({tag, " value"}, reg_q[i*8 +: 8], model[i]);
      chk({tag, " R9 strobes"}, got_stb[i], exp_stb[i]);
    end
  endtask

  task automatic byte_write(input int off, input logic [7:0] d);
    logic a;
    bus_start();
    wr_byte(8'hD2, a);              chk("R1 write address ack", a, 1);
    wr_byte(8'h80 | 8'(off), a);    chk("R2 command ack", a, 1);
    wr_byte(d, a);                  chk("R2/R7 data ack", a, 1);
    bus_stop();
    model_wr(off, d);
  endtask

  task automatic byte_read(input int off);
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, a);              chk("R1 write address ack", a, 1);
    wr_byte(8'h80 | 8'(off), a);    chk("R3 command ack", a, 1);
    bus_start();
    wr_byte(8'hD3, a);              chk("R1 read address ack", a, 1);
    rd_byte(1'b1, d);               chk("R3/R7 byte read data", d, exp_rd(off));
    bus_stop();
  endtask

  task automatic block_write(input int n, input logic [7:0] cnt_byte);
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, a);              chk("R1 write address ack", a, 1);
    wr_byte(8'h00, a);              chk("R4 block command ack", a, 1);
    wr_byte(cnt_byte, a);           chk("R4 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom_range(0, 255));
      wr_byte(d, a);                chk("R4 block data ack", a, 1);
      model_wr(i, d);
    end
    bus_stop();
  endtask

  task automatic block_read(input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, a);              chk("R1 write address ack", a, 1);
    wr_byte(8'h00, a);              chk("R5 block command ack", a, 1);
    bus_start();
    wr_byte(8'hD3, a);              chk("R1 read address ack", a, 1);
    rd_byte(1'b0, d);               chk("R5 returned count", d, NREG);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, d);       chk("R5/R7 block read data", d, exp_rd(i));
    end
    bus_stop();
  endtask

  task automatic wrong_addr(input logic [6:0] a7, input logic rw);
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte({a7, rw}, a);           chk("R1 foreign address not acked", a, 0);
    rd_byte(1'b1, d);               chk("R1 bus stays released", d, 8'hFF);
    bus_stop();
  endtask

  task automatic abort_write(input int off, input logic by_stop);
    logic a;
    bus_start();
    wr_byte(8'hD2, a);              chk("R10 address ack", a, 1);
    wr_byte(8'h80 | 8'(off), a);    chk("R10 command ack", a, 1);
    for (int i = 0; i < 4; i++) send_bit(~model[off % NREG][7-i]);
    if (by_stop) begin
      bus_stop();
    end else begin
      bus_start();
      wr_byte(8'hD2, a);            chk("R10 fresh address after start", a, 1);
      wr_byte(8'h80 | 8'(off), a);  chk("R10 command after start", a, 1);
      wr_byte(8'h3C, a);            chk("R10 data after start", a, 1);
      bus_stop();
      model_wr(off, 8'h3C);
    end
  endtask

  initial begin
    logic [6:0] a7;
    int op;
    vec   = 0;
    bad   = 0;
    done  = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      model[i]   = 8'h5A;
      exp_stb[i] = 0;
      got_stb[i] = 0;
    end
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    chk("R8 bus released", sda_oe, 0);
    chk("R8 no strobe", reg_wstb, 0);
    for (int i = 0; i < NREG; i++) chk("R8 default value", reg_q[i*8 +: 8], 8'h5A);

    // directed corners
    byte_write(3, 8'hC3);           chk_bank("R2 byte write");
    byte_read(3);
    byte_write(NREG, 8'h77);        chk_bank("R7 write past end");
    byte_write(127, 8'h11);         chk_bank("R7 write top offset");
    byte_read(NREG);
    byte_read(100);
    block_write(NREG, 8'h0F);       chk_bank("R4 full block write");
    block_read(NREG + 2);
    block_write(3, 8'h0F);          chk_bank("R6 block ended early");
    block_write(NREG + 3, 8'h02);   chk_bank("R4 count ignored, tail dropped");
    block_read(1);
    wrong_addr(7'h68, 1'b0);        chk_bank("R1 foreign write address");
    wrong_addr(7'h6B, 1'b1);        chk_bank("R1 foreign read address");
    abort_write(5, 1'b1);           chk_bank("R10 stop mid byte");
    abort_write(6, 1'b0);           chk_bank("R10 start mid byte");

    // random mix
    for (int t = 0; t < 40; t++) begin
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin
          byte_write(($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 127))
                                                 : int'($urandom_range(0, NREG + 2)),
                     8'($urandom_range(0, 255)));
          chk_bank("R2 random byte write");
        end
        1: byte_read(int'($urandom_range(0, NREG + 4)));
        2: begin
          block_write(int'($urandom_range(1, NREG + 2)), 8'($urandom_range(0, 255)));
          chk_bank("R6 random block write");
        end
        3: block_read(int'($urandom_range(1, NREG + 2)));
        4: begin
          a7 = 7'($urandom_range(0, 127));
          if (a7 == 7'h69) a7 = 7'h2A;
          wrong_addr(a7, 1'($urandom_range(0, 1)));
          chk_bank("R1 random foreign address");
        end
        default: begin
          abort_write(int'($urandom_range(0, NREG - 1)), 1'($urandom_range(0, 1)));
          chk_bank("R10 random abort");
        end
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule